// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Masking

This block sits beside a small CPU core and decides which pending interrupt, if any, the core should take next. Each user source keeps a pending flag, an enable input and a 3-bit priority field. A bank of trap sources sits above them at fixed levels 8 to 15. The controller holds the CPU's current priority level. Every cycle it picks the strongest pending source whose level is strictly above that CPU level. It presents that source as a vector number with a request strobe and the level of the request.

When the core acknowledges, the controller saves the current CPU level on an internal stack and raises the level to that of the accepted request. A return-from-interrupt pulse pops the saved level back. Three software controls narrow what may be taken:
- a direct write of the CPU level, where a value of 7 shuts out every user source;
- a nesting-off bit that shuts out user sources while any routine is in service;
- a quiet window that holds off priorities 1 to 6 for a programmed number of cycles while letting level 7 through.

None of these controls masks a trap. Pending flags are cleared only by software, so a flag that is still set when its routine returns asks for service again at once.

Top module: `irq_prio_ctrl`

## Requirements
- R1: User source i can request only when its pending flag is 1, src_en[i] is 1 and its priority field is nonzero. A source whose priority is 0 never requests.
- R2: req is 1 only when some candidate's level is strictly greater than cpu_lvl. The highest level wins, and equal-level user sources resolve to the lowest index. vec_id is i for user source i and N_SRC+t for trap t, and req_lvl is the winner's level.
- R3: Trap t has fixed level 8+t. Its pending flag is set by trap_set[t] and cleared by trap_clr[t]. A pending trap requests whenever its level exceeds cpu_lvl, whatever the values of src_en, nest_off and the quiet window.
- R4: A cycle with lvl_we=1 (and neither ack-with-req nor a reti pop) loads cpu_lvl with {0,lvl_wdata} on the next cycle. With cpu_lvl at 7, no user source requests.
- R5: While nest_off=1 and at least one level is saved on the stack, no user source requests. Traps still request.
- R6: A cycle with quiet_we=1 loads a count N from quiet_cycles. For the next N cycles, user sources with priority 1 to 6 cannot request, while priority 7 sources can. A new load restarts the count, and after the window requests resume.
- R7: After reset every priority field reads 4 (field i at prio_rd bits 3i+2:3i), cpu_lvl is 0 and req is 0.
- R8: In a cycle with ack=1 and req=1, the old cpu_lvl is pushed and cpu_lvl becomes req_lvl on the next cycle. Otherwise a reti with a non-empty stack restores the most recently saved level. Acknowledge clears no flag, so a source still pending requests again after the return.
- R9: The stack holds 8 levels. An acknowledge with 8 levels saved still raises cpu_lvl but saves nothing, and it sets the pending flag of trap 0 (level 8).
- R10: When src_set[i] and src_clr[i] are both 1 in a cycle, the flag ends set. A cycle with prio_we=1 writes prio_wdata into field prio_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| src_set | input | N_SRC | Per-source pulse setting the pending flag |
| src_clr | input | N_SRC | Per-source pulse clearing the pending flag |
| src_en | input | N_SRC | Per-source enable |
| prio_we | input | 1 | Priority field write strobe |
| prio_sel | input | SEL_W | Source whose priority is written |
| prio_wdata | input | 3 | New priority value |
| prio_rd | output | 3*N_SRC | All priority fields, field i at bits 3i+2:3i |
| trap_set | input | N_TRAP | Per-trap pulse setting the trap flag |
| trap_clr | input | N_TRAP | Per-trap pulse clearing the trap flag |
| lvl_we | input | 1 | CPU level write strobe |
| lvl_wdata | input | 3 | CPU level value written |
| nest_off | input | 1 | Blocks user preemption of a routine in service |
| quiet_we | input | 1 | Loads the quiet window counter |
| quiet_cycles | input | QUIET_W | Length of the quiet window in cycles |
| ack | input | 1 | CPU takes the presented request |
| reti | input | 1 | Return from interrupt, pops the saved level |
| req | output | 1 | A request above the CPU level is presented |
| vec_id | output | ID_W | Vector number of the presented request |
| req_lvl | output | 4 | Level of the presented request |
| cpu_lvl | output | 4 | Current CPU priority level |

## Verification
A corrupted pending flag, priority field or quiet counter shows at the request outputs in the same cycle, because the selection is combinational from those registers. It appears as a wrong vector, a missing strobe or a request that comes early or late. A bad saved-level stack stays hidden until the matching return: cpu_lvl then comes back with the wrong value, and requests that should be masked get through, or the reverse. The bench therefore compares req, vec_id, req_lvl, cpu_lvl and prio_rd against a reference model on every cycle, with deep nesting, overflow and window reloads driven on purpose.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W  = 4;
  localparam int PRIO_W = 3;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_RESET    = 3'd4;
  localparam prio_t PRIO_TOP_USER = 3'd7;
  localparam lvl_t  TRAP_BASE     = 4'd8;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_pkg::*; #(
  parameter int N_SRC  = 8,
  parameter int N_TRAP = 8,
  parameter int ID_W   = $clog2(N_SRC + N_TRAP)
) (
  input  logic [N_SRC-1:0]        usr_ok,
  input  logic [N_SRC*PRIO_W-1:0] usr_prio,
  input  logic [N_TRAP-1:0]       trap_ok,
  input  lvl_t                    cpu_lvl,
  output logic                    req,
  output logic [ID_W-1:0]         vec_id,
  output lvl_t                    req_lvl
);
  always_comb begin
    lvl_t best;
    lvl_t cand;
    best   = cpu_lvl;
    req    = 1'b0;
    vec_id = '0;
    // strict compare: earlier (lower) user index keeps ties
    for (int i = 0; i < N_SRC; i++) begin
      cand = {1'b0, usr_prio[i*PRIO_W +: PRIO_W]};
      if (usr_ok[i] && (cand > best)) begin
        best   = cand;
        req    = 1'b1;
        vec_id = ID_W'(i);
      end
    end
    for (int t = 0; t < N_TRAP; t++) begin
      cand = TRAP_BASE + lvl_t'(t);
      if (trap_ok[t] && (cand > best)) begin
        best   = cand;
        req    = 1'b1;
        vec_id = ID_W'(N_SRC + t);
      end
    end
    req_lvl = best;
  end
endmodule

// File: rtl/irq_quiet_timer.sv
module irq_quiet_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack import irq_pkg::*; #(
  parameter int DEPTH   = 8,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  lvl_t               push_lvl,
  input  logic               pop,
  input  logic               sw_we,
  input  prio_t              sw_lvl,
  output lvl_t               cpu_lvl,
  output logic [DEPTH_W-1:0] depth,
  output logic               ovf
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t               lvl_q, lvl_d;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic [DEPTH_W-1:0] depth_m1;
  logic               full, empty, wr_en, state_en;
  lvl_t               mem_q [DEPTH];

  assign full     = (depth_q == DEPTH_W'(DEPTH));
  assign empty    = (depth_q == '0);
  assign depth_m1 = depth_q - 1'b1;

  always_comb begin
    lvl_d   = lvl_q;
    depth_d = depth_q;
    wr_en   = 1'b0;
    ovf     = 1'b0;
    if (push) begin
      lvl_d = push_lvl;
      if (!full) begin
        wr_en   = 1'b1;
        depth_d = depth_q + 1'b1;
      end else begin
        ovf = 1'b1;
      end
    end else if (pop && !empty) begin
      lvl_d   = mem_q[depth_m1[IDX_W-1:0]];
      depth_d = depth_m1;
    end else if (sw_we) begin
      lvl_d = {1'b0, sw_lvl};
    end
    state_en = push || (pop && !empty) || sw_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      depth_q <= '0;
    end else if (state_en) begin
      lvl_q   <= lvl_d;
      depth_q <= depth_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[depth_q[IDX_W-1:0]] <= lvl_q;
  end

  assign cpu_lvl = lvl_q;
  assign depth   = depth_q;

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(DEPTH));
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (depth_q == DEPTH_W'(DEPTH)));
  p_pop_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (depth_q == $past(depth_q) - 1'b1));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl import irq_pkg::*; #(
  parameter int N_SRC       = 8,
  parameter int N_TRAP      = 8,
  parameter int STACK_DEPTH = 8,
  parameter int QUIET_W     = 16,
  parameter int SEL_W       = $clog2(N_SRC),
  parameter int ID_W        = $clog2(N_SRC + N_TRAP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_set,
  input  logic [N_SRC-1:0]        src_clr,
  input  logic [N_SRC-1:0]        src_en,
  input  logic                    prio_we,
  input  logic [SEL_W-1:0]        prio_sel,
  input  logic [PRIO_W-1:0]       prio_wdata,
  output logic [N_SRC*PRIO_W-1:0] prio_rd,
  input  logic [N_TRAP-1:0]       trap_set,
  input  logic [N_TRAP-1:0]       trap_clr,
  input  logic                    lvl_we,
  input  logic [PRIO_W-1:0]       lvl_wdata,
  input  logic                    nest_off,
  input  logic                    quiet_we,
  input  logic [QUIET_W-1:0]      quiet_cycles,
  input  logic                    ack,
  input  logic                    reti,
  output logic                    req,
  output logic [ID_W-1:0]         vec_id,
  output logic [LVL_W-1:0]        req_lvl,
  output logic [LVL_W-1:0]        cpu_lvl
);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);

  logic               rst_n_s;
  logic [N_SRC-1:0]   flag_q, flag_d, usr_ok;
  logic [N_TRAP-1:0]  tflag_q, tflag_d, ovf_mask;
  logic               flag_en, tflag_en;
  prio_t              prio_q [N_SRC];
  logic               quiet_act, in_service, stk_ovf, push;
  logic [DEPTH_W-1:0] depth;

  irq_rst_sync u_rst_sync (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  assign ovf_mask   = {{(N_TRAP-1){1'b0}}, stk_ovf};
  assign in_service = (depth != '0);
  assign push       = ack && req;

  always_comb begin
    flag_en  = (|src_set) || (|src_clr);
    flag_d   = (flag_q & ~src_clr) | src_set;
    tflag_en = (|trap_set) || (|trap_clr) || stk_ovf;
    tflag_d  = (tflag_q & ~trap_clr) | trap_set | ovf_mask;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      flag_q  <= '0;
      tflag_q <= '0;
    end else begin
      if (flag_en)  flag_q  <= flag_d;
      if (tflag_en) tflag_q <= tflag_d;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic  wr_hit;
    logic  held_off;
    assign wr_hit = prio_we && (prio_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)    prio_q[g] <= PRIO_RESET;
      else if (wr_hit) prio_q[g] <= prio_wdata;
    end
    assign held_off = (quiet_act && (prio_q[g] != PRIO_TOP_USER)) ||
                      (nest_off && in_service);
    assign usr_ok[g] = flag_q[g] && src_en[g] && (prio_q[g] != '0) && !held_off;
    assign prio_rd[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  irq_quiet_timer #(.CNT_W(QUIET_W)) u_quiet (
    .clk(clk), .rst_n(rst_n_s), .load(quiet_we), .load_val(quiet_cycles),
    .active(quiet_act)
  );

  irq_level_stack #(.DEPTH(STACK_DEPTH), .DEPTH_W(DEPTH_W)) u_stack (
    .clk(clk), .rst_n(rst_n_s), .push(push), .push_lvl(req_lvl), .pop(reti),
    .sw_we(lvl_we), .sw_lvl(lvl_wdata), .cpu_lvl(cpu_lvl), .depth(depth),
    .ovf(stk_ovf)
  );

  irq_arbiter #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .ID_W(ID_W)) u_arb (
    .usr_ok(usr_ok), .usr_prio(prio_rd), .trap_ok(tflag_q), .cpu_lvl(cpu_lvl),
    .req(req), .vec_id(vec_id), .req_lvl(req_lvl)
  );

  p_above_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    req |-> (req_lvl > cpu_lvl));
  p_user_pending_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req && vec_id < ID_W'(N_SRC)) |->
      (flag_q[vec_id[SEL_W-1:0]] && src_en[vec_id[SEL_W-1:0]]));
  p_trap_level_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req && vec_id >= ID_W'(N_SRC)) |->
      (req_lvl == TRAP_BASE + lvl_t'(vec_id - ID_W'(N_SRC))));
  p_nest_trap_only_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (nest_off && in_service && req) |-> (vec_id >= ID_W'(N_SRC)));
  p_quiet_spares7_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (quiet_act && req && vec_id < ID_W'(N_SRC)) |-> (req_lvl == lvl_t'(7)));
  p_ack_raise_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    push |=> (cpu_lvl == $past(req_lvl)));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  localparam int NS = 8;
  localparam int NT = 8;
  localparam int QW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0] src_set, src_clr, src_en;
  logic          prio_we;
  logic [2:0]    prio_sel, prio_wdata, lvl_wdata;
  logic [NS*3-1:0] prio_rd;
  logic [NT-1:0] trap_set, trap_clr;
  logic          lvl_we, nest_off, quiet_we, ack, reti, req;
  logic [QW-1:0] quiet_cycles;
  logic [3:0]    vec_id, req_lvl, cpu_lvl;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  logic [NS-1:0] m_flag;
  logic [NT-1:0] m_tflag;
  int m_prio [NS];
  int m_stk [8];
  int m_cpu, m_depth, m_cnt;
  int e_req, e_vec, e_lvl;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(NS), .N_TRAP(NT), .STACK_DEPTH(8), .QUIET_W(QW)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr), .src_en(src_en),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata), .prio_rd(prio_rd),
    .trap_set(trap_set), .trap_clr(trap_clr), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .nest_off(nest_off), .quiet_we(quiet_we), .quiet_cycles(quiet_cycles),
    .ack(ack), .reti(reti), .req(req), .vec_id(vec_id), .req_lvl(req_lvl),
    .cpu_lvl(cpu_lvl)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void calc();
    int best;
    bit ok;
    best  = m_cpu;
    e_req = 0;
    e_vec = 0;
    for (int i = 0; i < NS; i++) begin
      ok = m_flag[i] && src_en[i] && (m_prio[i] != 0) &&
           !((m_cnt != 0) && (m_prio[i] != 7)) && !(nest_off && (m_depth != 0));
      if (ok && m_prio[i] > best) begin best = m_prio[i]; e_req = 1; e_vec = i; end
    end
    for (int t = 0; t < NT; t++) begin
      if (m_tflag[t] && (8 + t) > best) begin best = 8 + t; e_req = 1; e_vec = NS + t; end
    end
    e_lvl = best;
  endfunction

  function automatic int packed_prio();
    int v;
    v = 0;
    for (int i = 0; i < NS; i++) v = v | (m_prio[i] << (3 * i));
    return v;
  endfunction

  task automatic clear_pulses();
    src_set = '0; src_clr = '0; prio_we = 0; trap_set = '0; trap_clr = '0;
    lvl_we = 0; quiet_we = 0; ack = 0; reti = 0;
  endtask

  // called at a falling edge with inputs applied
  task automatic step(input string tag);
    bit ovf;
    #1;
    calc();
    chk(tag, "req", int'(req), e_req);
    if (e_req != 0) begin
      chk(tag, "vec_id", int'(vec_id), e_vec);
      chk(tag, "req_lvl", int'(req_lvl), e_lvl);
    end
    chk(tag, "cpu_lvl", int'(cpu_lvl), m_cpu);
    chk(tag, "prio_rd", int'(prio_rd), packed_prio());
    @(posedge clk);
    ovf = 0;
    if (ack && e_req != 0) begin
      if (m_depth < 8) begin m_stk[m_depth] = m_cpu; m_depth++; end
      else ovf = 1;
      m_cpu = e_lvl;
    end else if (reti && m_depth > 0) begin
      m_depth--;
      m_cpu = m_stk[m_depth];
    end else if (lvl_we) begin
      m_cpu = int'(lvl_wdata);
    end
    m_flag  = (m_flag & ~src_clr) | src_set;
    m_tflag = (m_tflag & ~trap_clr) | trap_set | {7'b0, ovf};
    if (prio_we) m_prio[prio_sel] = int'(prio_wdata);
    if (quiet_we) m_cnt = int'(quiet_cycles);
    else if (m_cnt != 0) m_cnt--;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic wr_prio(input int sel, input int val, input string tag);
    prio_we = 1; prio_sel = 3'(sel); prio_wdata = 3'(val);
    step(tag);
  endtask

  task automatic wr_lvl(input int val, input string tag);
    lvl_we = 1; lvl_wdata = 3'(val);
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired before completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; clear_pulses(); src_en = '0; nest_off = 0; quiet_cycles = '0;
    prio_sel = '0; prio_wdata = '0; lvl_wdata = '0;
    m_flag = '0; m_tflag = '0; m_cpu = 0; m_depth = 0; m_cnt = 0;
    for (int i = 0; i < NS; i++) m_prio[i] = 4;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R7: reset state
    chk("R7", "prio_rd reset", int'(prio_rd), 24'h924924);
    chk("R7", "req reset", int'(req), 0);
    chk("R7", "cpu_lvl reset", int'(cpu_lvl), 0);
    step("R7");

    // R1: flag without enable, then enable, then a priority-0 source
    src_set = 8'h04; step("R1");
    step("R1");
    src_en = 8'hFF; step("R1");
    wr_prio(1, 0, "R1");
    src_set = 8'h02; step("R1");
    step("R1");

    // R10: set beats clear; R2: tie goes to lowest index
    src_set = 8'h01; src_clr = 8'h01; step("R10");
    step("R2");
    chk("R2", "tie winner", int'(vec_id), 0);
    wr_prio(5, 6, "R10");
    src_set = 8'h20; step("R2");
    step("R2");

    // R8: ack raises, reti restores, uncleared flag re-requests
    ack = 1; step("R8");
    chk("R8", "cpu after ack", int'(cpu_lvl), 6);
    step("R8");
    reti = 1; step("R8");
    chk("R8", "re-request vec", int'(vec_id), 5);
    step("R8");
    src_clr = 8'h20; step("R8");

    // R4: level 7 blocks users, even priority 7
    wr_lvl(7, "R4");
    wr_prio(6, 7, "R4");
    src_set = 8'h40; step("R4");
    step("R4");
    chk("R4", "no user at level 7", int'(req), 0);

    // R3: trap above level 7
    trap_set = 8'h08; step("R3");
    step("R3");
    ack = 1; step("R3");
    step("R3");
    reti = 1; step("R3");
    trap_clr = 8'h08; step("R3");
    wr_lvl(0, "R4");
    src_clr = 8'h40; step("R6");

    // R6: quiet window of 3, reload, level 7 spared
    quiet_we = 1; quiet_cycles = 3; step("R6");
    chk("R6", "blocked at start", int'(req), 0);
    repeat (3) step("R6");
    quiet_we = 1; quiet_cycles = 5; step("R6");
    step("R6");
    quiet_we = 1; quiet_cycles = 5; step("R6");
    repeat (6) step("R6");
    quiet_we = 1; quiet_cycles = 4; step("R6");
    src_set = 8'h40; step("R6");
    chk("R6", "level 7 in window", int'(vec_id), 6);
    trap_set = 8'h04; step("R3");
    trap_clr = 8'h04; src_clr = 8'h40; step("R3");
    repeat (3) step("R6");

    // R5: nesting off
    nest_off = 1;
    ack = 1; step("R5");
    src_set = 8'h20; step("R5");
    step("R5");
    chk("R5", "no user preempt", int'(req), 0);
    trap_set = 8'h02; step("R5");
    step("R5");
    ack = 1; step("R5");
    reti = 1; step("R5");
    trap_clr = 8'h02; step("R5");
    reti = 1; step("R5");
    nest_off = 0; src_clr = 8'h21; step("R5");

    // R9: nine nested accepts, the ninth overflows
    for (int k = 0; k < 9; k++) begin
      ack = 1; step("R9");
      wr_lvl(0, "R9");
    end
    chk("R9", "overflow trap vec", int'(vec_id), NS);
    step("R9");
    for (int k = 0; k < 9; k++) begin reti = 1; step("R9"); end
    trap_clr = 8'h01; step("R9");

    // random mix
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 4 == 0) src_set = NS'($urandom & $urandom);
      if ($urandom % 6 == 0) src_clr = NS'($urandom & $urandom);
      if ($urandom % 16 == 0) src_en = NS'($urandom);
      if ($urandom % 8 == 0) begin prio_we = 1; prio_sel = 3'($urandom); prio_wdata = 3'($urandom); end
      if ($urandom % 48 == 0) trap_set = NT'(1 << ($urandom % NT));
      if ($urandom % 4 == 0) trap_clr = NT'($urandom);
      if ($urandom % 32 == 0) begin lvl_we = 1; lvl_wdata = 3'($urandom); end
      if ($urandom % 64 == 0) nest_off = ~nest_off;
      if ($urandom % 64 == 0) begin quiet_we = 1; quiet_cycles = QW'($urandom % 20); end
      ack = ($urandom % 2 == 0);
      reti = (m_depth > 0) && ($urandom % 3 == 0);
      step("R2");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule